// File: doc/BRIEF.md
# DRAM refresh and initialization sequencer

This block sits on the controller side of an asynchronous DRAM with a 4-bit data path. It drives the row strobe, column strobe and write strobe, and the row address, so that the array keeps its contents. After reset it waits out a fixed power-up pause, measured in clock cycles. It then runs a burst of initialization RAS cycles, each of which is a refresh. After that it raises `ready` and issues one refresh per interval. The interval is the retention window divided by the number of rows.

Each refresh takes one of two forms, chosen by `cbr_mode` when the refresh starts. A row-addressed refresh keeps CAS high and puts an internal row counter on the address pins. A column-before-row refresh lowers CAS ahead of RAS and drives no address. Between refreshes the bus is lent to a host through a request/grant pair. A refresh that falls due during a host access waits for that access to end, and then runs before the host is granted again. Data transfer itself is outside this block. All timing values are cycle-count parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n` and `cas_n` are high, and `addr_oe`, `ready` and `host_gnt` are low.
- R2: After reset is released, `ras_n` stays high for at least PAUSE_US*CLK_PER_US clock cycles.
- R3: After the pause, exactly INIT_CYCLES refresh RAS cycles occur before `ready` rises. Once high, `ready` stays high until the next reset.
- R4: In a row-addressed refresh (`cbr_mode`=0 at start), `cas_n` stays high and `addr_oe` is high while `ras_n` is low. `row_addr` shows a counter that starts at 0 after reset and advances by one after each completed row-addressed refresh. The counter wraps modulo the row count: 2048 rows on 11 bits when LARGE_ARRAY=0, and 4096 rows on 12 bits when LARGE_ARRAY=1.
- R5: In a column-before-row refresh (`cbr_mode`=1 at start), `cas_n` is low for at least T_CSR cycles before `ras_n` falls and for at least T_CHR cycles after. `addr_oe` stays low, and the row counter does not move.
- R6: When the initialization refreshes are column-before-row, `cas_n` stays low from the first of them to the last, and only `ras_n` toggles.
- R7: `we_n` is high at every refresh.
- R8: Once `ready` is high, and with no host grant nearby, consecutive refreshes of the same form start exactly INTERVAL cycles apart. INTERVAL = floor(window_us*CLK_PER_US/rows), where the window is 32000 µs for 2048 rows and 64000 µs for 4096 rows.
- R9: A `host_req` seen while idle with no refresh due is answered with `host_gnt`. While `host_gnt` is high, both strobes stay high. The grant holds as long as `host_req` stays high.
- R10: A refresh that falls due during a grant starts after `host_req` drops, before any further grant.
- R11: The refresh form is taken from `cbr_mode` at the start of each refresh, so a change of `cbr_mode` takes effect at the next refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cbr_mode | input | 1 | Refresh form: 1 column-before-row, 0 row-addressed |
| host_req | input | 1 | Host asks for the DRAM bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | ROW_W | Refresh row from the internal counter |
| addr_oe | output | 1 | Row address is driven for a refresh |
| ready | output | 1 | Initialization complete |
| host_gnt | output | 1 | Host owns the bus |

## Verification
The assertions assume that the host keeps `host_req` high for as long as it uses the bus. They also assume that the parameters pass the elaboration checks, so that a whole refresh cycle fits inside one interval. The stimulus changes `cbr_mode` only after a refresh has begun its RAS phase, never between reset and a refresh start. It drops `host_req` only after seeing a grant. It also holds one grant longer than an interval, so that a refresh has to wait behind the host.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [2:0] {
      S_PAUSE,
      S_IDLE,
      S_HOST,
      S_CSETUP,
      S_RAS,
      S_PRE
   } seq_state_e;

   // bits needed to count 0 .. v-1
   function automatic int unsigned cnt_width(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction

   function automatic int unsigned max4(input int unsigned a, b, c, d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
   import dram_rfsh_pkg::*;
#(
   parameter int unsigned PERIOD = 1562
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int unsigned W = cnt_width(PERIOD);

   generate
      if (PERIOD == 1) begin : g_every
         assign tick = en;
      end else begin : g_count
         logic [W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt <= '0;
            else if (!en)                      cnt <= '0;
            else if (cnt == W'(PERIOD - 1))    cnt <= '0;
            else                               cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == W'(PERIOD - 1));

         // R8: a pulse never repeats on the next cycle
         a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
   parameter int unsigned ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [ROW_W-1:0] row
);
   // power-of-two row count: natural wrap of the adder gives modulo rows
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row <= '0;
      else if (adv) row <= row + 1'b1;
   end
endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
   import dram_rfsh_pkg::*;
#(
   parameter int unsigned PAUSE_CYC   = 20000,
   parameter int unsigned INIT_CYCLES = 8,
   parameter int unsigned T_CSR       = 2,
   parameter int unsigned T_RAS       = 6,
   parameter int unsigned T_RP        = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cbr_mode,
   input  logic host_req,
   input  logic tick,
   output logic ras_n,
   output logic cas_n,
   output logic addr_oe,
   output logic row_adv,
   output logic ready,
   output logic host_gnt
);
   localparam int unsigned TW = cnt_width(max4(PAUSE_CYC, T_CSR, T_RAS, T_RP));
   localparam int unsigned IW = cnt_width(INIT_CYCLES + 1);

   seq_state_e    st, st_d;
   logic [TW-1:0] tcnt, tcnt_d;
   logic [IW-1:0] init_left;
   logic          cur_cbr, cur_cbr_d;
   logic          due, start, init_dec, in_init;

   assign in_init = (init_left != '0);

   always_comb begin
      st_d      = st;
      tcnt_d    = tcnt + 1'b1;
      cur_cbr_d = cur_cbr;
      start     = 1'b0;
      row_adv   = 1'b0;
      init_dec  = 1'b0;
      case (st)
         S_PAUSE:  if (tcnt == TW'(PAUSE_CYC - 1)) start = 1'b1;
         S_IDLE: begin
            tcnt_d = '0;
            if (due)           start = 1'b1;
            else if (host_req) st_d  = S_HOST;
         end
         S_HOST: begin
            tcnt_d = '0;
            if (!host_req) st_d = S_IDLE;
         end
         S_CSETUP: if (tcnt == TW'(T_CSR - 1)) begin
            st_d   = S_RAS;
            tcnt_d = '0;
         end
         S_RAS: if (tcnt == TW'(T_RAS - 1)) begin
            st_d     = S_PRE;
            tcnt_d   = '0;
            row_adv  = !cur_cbr;
            init_dec = in_init;
         end
         S_PRE: if (tcnt == TW'(T_RP - 1)) begin
            tcnt_d = '0;
            if (in_init && cur_cbr)  st_d  = S_RAS;   // CAS stays low, RAS only
            else if (in_init || due) start = 1'b1;
            else if (host_req)       st_d  = S_HOST;
            else                     st_d  = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
      if (start) begin
         cur_cbr_d = cbr_mode;
         tcnt_d    = '0;
         st_d      = cbr_mode ? S_CSETUP : S_RAS;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_PAUSE;
         tcnt      <= '0;
         cur_cbr   <= 1'b0;
         due       <= 1'b0;
         init_left <= IW'(INIT_CYCLES);
      end else begin
         st      <= st_d;
         tcnt    <= tcnt_d;
         cur_cbr <= cur_cbr_d;
         due     <= tick | (due & ~start);
         if (init_dec) init_left <= init_left - 1'b1;
      end
   end

   assign ras_n    = (st != S_RAS);
   assign cas_n    = !(cur_cbr && (st == S_CSETUP || st == S_RAS ||
                                   (st == S_PRE && in_init)));
   assign addr_oe  = (st == S_RAS) && !cur_cbr;
   assign ready    = !in_init;
   assign host_gnt = (st == S_HOST);

   a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);
   a_r9_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
      host_gnt && host_req |=> host_gnt);
   a_r10_due_before_host: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) && due |=> !host_gnt);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import dram_rfsh_pkg::*;
#(
   parameter bit          LARGE_ARRAY = 1'b1,
   parameter int unsigned CLK_PER_US  = 100,
   parameter int unsigned PAUSE_US    = 200,
   parameter int unsigned INIT_CYCLES = 8,
   parameter int unsigned T_CSR       = 2,
   parameter int unsigned T_CHR       = 2,
   parameter int unsigned T_RAS       = 6,
   parameter int unsigned T_RP        = 5,
   localparam int unsigned ROW_W      = LARGE_ARRAY ? 12 : 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cbr_mode,
   input  logic             host_req,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [ROW_W-1:0] row_addr,
   output logic             addr_oe,
   output logic             ready,
   output logic             host_gnt
);
   localparam int unsigned ROWS      = 1 << ROW_W;
   localparam int unsigned WINDOW_US = LARGE_ARRAY ? 64000 : 32000;
   localparam int unsigned INTERVAL  = WINDOW_US * CLK_PER_US / ROWS;
   localparam int unsigned PAUSE_CYC = PAUSE_US * CLK_PER_US;
   localparam int unsigned SW        = cnt_width(PAUSE_CYC + 1);
   localparam int unsigned CW        = cnt_width(T_CSR + 1);

   generate
      if (T_CSR < 1 || T_RAS < 1 || T_RP < 1 || PAUSE_CYC < 1)
         $error("strobe timings and pause must be at least one cycle");
      if (T_CHR > T_RAS) $error("CAS hold cannot exceed RAS low time");
      if (T_CSR > T_RP)  $error("chained CAS setup must fit in precharge");
      if (INIT_CYCLES < 1) $error("at least one initialization refresh needed");
      if (INTERVAL <= T_CSR + T_RAS + T_RP)
         $error("refresh interval shorter than one refresh cycle");
   endgenerate

   logic tick, row_adv;

   rfsh_interval_timer #(.PERIOD(INTERVAL)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(ready), .tick(tick)
   );

   rfsh_row_counter #(.ROW_W(ROW_W)) u_rows (
      .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(row_addr)
   );

   rfsh_seq_fsm #(
      .PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES),
      .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .host_req(host_req),
      .tick(tick), .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe),
      .row_adv(row_adv), .ready(ready), .host_gnt(host_gnt)
   );

   // refresh never writes; a low write strobe would change the device mode
   assign we_n = 1'b1;

   // checker state for timing windows
   logic [SW-1:0] since_rst;
   logic [CW-1:0] cas_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
         cas_run   <= '0;
      end else begin
         if (since_rst != SW'(PAUSE_CYC)) since_rst <= since_rst + 1'b1;
         if (cas_n)                       cas_run   <= '0;
         else if (cas_run != CW'(T_CSR))  cas_run   <= cas_run + 1'b1;
      end
   end

   a_r2_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> since_rst == SW'(PAUSE_CYC));
   a_r5_cas_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) && !cas_n |-> cas_run == CW'(T_CSR));
   a_r4_row_moves_after_raso: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_addr) |-> $past(addr_oe) && ras_n);
   a_r9_strobes_idle_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
      host_gnt |-> ras_n && cas_n && !addr_oe);
endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
   localparam int unsigned CPU   = 1;
   localparam int unsigned ROWS  = 2048;
   localparam int unsigned INTV  = 32000 * CPU / ROWS;   // 15
   localparam int unsigned PAUSE = 200 * CPU;
   localparam int unsigned NINIT = 8;
   localparam int unsigned TCSR  = 2;
   localparam int unsigned TCHR  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cbr_mode = 1'b1;
   logic host_req = 1'b0;
   logic ras_n, cas_n, we_n, addr_oe, ready, host_gnt;
   logic [10:0] row_addr;

   always #5 clk = ~clk;

   dram_refresh_seq #(
      .LARGE_ARRAY(1'b0), .CLK_PER_US(CPU), .PAUSE_US(200), .INIT_CYCLES(NINIT),
      .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(4), .T_RP(3)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .host_req(host_req),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr),
      .addr_oe(addr_oe), .ready(ready), .host_gnt(host_gnt)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit exp_q[$];   // expected refresh forms, 1 = column-before-row

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver: pushes expected forms and waits for the monitor to consume them
   task automatic expect_refs(input bit cbr, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(cbr);
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // monitor state
   longint cyc = 0, since = 0, last_fall = 0;
   int     fall_cnt = 0, cas_run = 0, since_fall = 99, skip = 2, gnt_len = 0;
   int     cas_rises = 0;
   int     model_row = 0;
   bit     prev_ras = 1, prev_cas = 1, prev_gnt = 0, ready_prev = 0;
   bit     last_kind = 0, prev_fall_ready = 0, need_ref = 0, init_all_cbr = 1;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         exp_q.delete();
         fall_cnt = 0; since = 0; cas_run = 0; since_fall = 99; skip = 2;
         gnt_len = 0; cas_rises = 0; model_row = 0; need_ref = 0;
         prev_ras = 1; prev_cas = 1; prev_gnt = 0; ready_prev = 0;
         prev_fall_ready = 0; init_all_cbr = 1;
      end else begin
         bit kind;
         since++;
         if (prev_ras && !ras_n) begin
            kind = (exp_q.size() != 0) ? exp_q.pop_front() : cbr_mode;
            fall_cnt++;
            if (fall_cnt == 1) begin
               check(since >= PAUSE, "R2", "cycles before first RAS", since, PAUSE);
               cas_rises = 0;
            end
            check(we_n == 1'b1, "R7", "we_n at refresh", we_n, 1);
            check((!cas_n) == kind, "R11", "refresh form", !cas_n, kind);
            if (kind) begin
               check(cas_run >= TCSR, "R5", "CAS setup cycles", cas_run, TCSR);
               check(!addr_oe, "R5", "addr_oe in CBR", addr_oe, 0);
               since_fall = 0;
            end else begin
               check(cas_n && addr_oe, "R4", "cas_n&addr_oe", {cas_n, addr_oe}, 3);
               check(row_addr == model_row, "R4", "row address", row_addr, model_row);
               model_row = (model_row + 1) % ROWS;
            end
            if (fall_cnt <= NINIT && !kind) init_all_cbr = 0;
            if (fall_cnt == NINIT && init_all_cbr)
               check(cas_rises == 0, "R6", "CAS rises in init chain", cas_rises, 0);
            if (ready && prev_fall_ready && kind == last_kind && skip == 0)
               check(cyc - last_fall == INTV, "R8", "refresh spacing",
                     cyc - last_fall, INTV);
            if (skip > 0) skip--;
            last_fall = cyc; last_kind = kind; prev_fall_ready = ready; need_ref = 0;
         end else if (since_fall < TCHR) begin
            check(!cas_n, "R5", "CAS hold after RAS", cas_n, 0);
         end
         if (since_fall < 99) since_fall++;
         if (!prev_cas && cas_n) cas_rises++;
         cas_run = cas_n ? 0 : cas_run + 1;
         if (ready && !ready_prev)
            check(fall_cnt == NINIT, "R3", "refreshes before ready", fall_cnt, NINIT);
         if (!ready && ready_prev)
            check(0, "R3", "ready dropped", 0, 1);
         if (host_gnt) begin
            if (!prev_gnt) begin
               check(!need_ref, "R10", "grant before pending refresh", 1, 0);
               gnt_len = 0;
            end
            check(ras_n && cas_n, "R9", "strobes in grant", {ras_n, cas_n}, 3);
            gnt_len++;
            skip = 2;
         end
         if (prev_gnt && !host_gnt && gnt_len >= INTV) need_ref = 1;
         prev_ras = ras_n; prev_cas = cas_n; prev_gnt = host_gnt; ready_prev = ready;
      end
   end

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n = 1'b0;
      cbr_mode = mode;
      repeat (4) @(negedge clk);
      check(ras_n && cas_n, "R1", "strobes in reset", {ras_n, cas_n}, 3);
      check(!addr_oe && !ready && !host_gnt, "R1", "addr_oe/ready/gnt in reset",
            {addr_oe, ready, host_gnt}, 0);
      rst_n = 1'b1;
   endtask

   task automatic wait_gnt(input int limit);
      int k = 0;
      while (!host_gnt && k < limit) begin
         @(negedge clk);
         k++;
      end
      check(host_gnt, "R9", "grant after request", host_gnt, 1);
   endtask

   bit done = 0;

   initial begin
      // column-before-row init chain, then steady refresh
      do_reset(1'b1);
      expect_refs(1'b1, NINIT);
      expect_refs(1'b1, 4);
      check(ready, "R3", "ready after init", ready, 1);
      // switch form: takes effect at next start (R11)
      cbr_mode = 1'b0;
      expect_refs(1'b0, 5);
      // host access longer than an interval (R9, R10)
      host_req = 1'b1;
      wait_gnt(30);
      repeat (40) begin
         @(negedge clk);
         check(host_gnt, "R9", "grant held", host_gnt, 1);
      end
      host_req = 1'b0;
      @(negedge clk);
      host_req = 1'b1;
      wait_gnt(40);
      repeat (5) @(negedge clk);
      host_req = 1'b0;
      cbr_mode = 1'b1;
      expect_refs(1'b1, 3);
      // CBR refreshes must not have moved the counter; long run wraps it (R4)
      cbr_mode = 1'b0;
      expect_refs(1'b0, ROWS + 2);
      // row-addressed initialization after a fresh reset
      do_reset(1'b0);
      expect_refs(1'b0, NINIT);
      repeat (10) @(negedge clk);
      check(ready, "R3", "ready after row-addressed init", ready, 1);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule